// File: doc/BRIEF.md
# Message Object Transfer Engine

The block sits between a processor's register port and a bank of message objects that a CAN-style controller would use. Each object stores two mask words, two arbitration words, a control word and four 16-bit data words. Software never addresses the object bank directly. It loads a staging register set, picks the fields and the direction through a command mask, and then writes an object number to the request register. This starts one indirect transfer.

A transfer runs for a fixed number of clock cycles, and a busy bit is visible during it. A read toward the staging registers can also clear the interrupt-pending flag or the new-data flag of the object. A write toward the object bank can raise its transmit-request flag. The object bank is held in flops inside the block.

Top module: `msg_if_xfer`

## Requirements
- R1: After reset every staging register, the command mask, the request register and every stored object field read as 0.
- R2: Writing an object number from 1 to 32 (taken from write data bits 15:0) to the request register at offset 0 while idle starts a transfer. Bit 15 of offset 0 then reads 1 for exactly 6 clock cycles after the write edge and 0 afterwards. Bits 5:0 read the accepted number.
- R3: A request value of 0, or above 32, starts nothing. The busy bit stays 0 and no register or object changes.
- R4: Any register write while busy is ignored. This includes a new request.
- R5: With command-mask bit 7 set, the transfer copies the selected staging fields into the object. Bit 6 selects both mask words, bit 5 both arbitration words, bit 4 the control word, bit 1 data words 0-1 (bytes 0-3) and bit 0 data words 2-3 (bytes 4-7).
- R6: With command-mask bit 7 clear, the transfer copies the selected object fields into the staging registers, using the same field groups as R5.
- R7: A field group that is not selected keeps its previous value at the destination.
- R8: On a read transfer, command-mask bit 3 clears control bit 13 (interrupt pending) in the stored object, and bit 2 clears control bit 15 (new data). The staging copy receives the value from before the clear.
- R9: On a write transfer, command-mask bit 2 sets control bit 8 (transmit request) in the stored object, after any control-word copy.
- R10: Register map: offset 0 request/busy, 1 command mask (bits 7:0), 2 and 3 mask words, 4 and 5 arbitration words, 6 control word, 7 to 10 data words 0 to 3, each 16 bits wide and zero-extended on read. Other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |

## Verification
The assertions assume that the command mask stays fixed for the length of a transfer, and the block itself enforces this by dropping writes while busy. They also assume that a request carries its number in the low 16 bits. The stimulus loads the mask and the staging fields only while idle. It pokes the request register during a busy window on purpose, so that the dropped write can be observed. It uses object numbers that include both ends, 1 and 32, and out-of-range values such as 0, 33 and 257.

// File: rtl/msg_if_pkg.sv
package msg_if_pkg;
  localparam int FLD_N  = 9;
  // field slots inside an object / staging set
  localparam int F_MSK1 = 0;
  localparam int F_MSK2 = 1;
  localparam int F_ARB1 = 2;
  localparam int F_ARB2 = 3;
  localparam int F_CTL  = 4;
  localparam int F_DAT0 = 5;
  // command mask bits
  localparam int CM_DIR   = 7;
  localparam int CM_MSK   = 6;
  localparam int CM_ARB   = 5;
  localparam int CM_CTL   = 4;
  localparam int CM_CLRIP = 3;
  localparam int CM_NDTR  = 2;
  localparam int CM_DLO   = 1;
  localparam int CM_DHI   = 0;
  // control word bits
  localparam int CT_NEWDAT = 15;
  localparam int CT_INTPND = 13;
  localparam int CT_TXRQ   = 8;

  typedef logic [15:0] half_t;
  typedef half_t [FLD_N-1:0] obj_t;

  function automatic logic [FLD_N-1:0] field_sel(input logic [7:0] cm);
    field_sel = {cm[CM_DHI], cm[CM_DHI], cm[CM_DLO], cm[CM_DLO], cm[CM_CTL],
                 cm[CM_ARB], cm[CM_ARB], cm[CM_MSK], cm[CM_MSK]};
  endfunction
endpackage

// File: rtl/msg_xfer_seq.sv
module msg_xfer_seq #(
  parameter int NUM_OBJ  = 32,
  parameter int XFER_CYC = 6,
  localparam int NUM_W   = $clog2(NUM_OBJ + 1),
  localparam int CNT_W   = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [15:0]      num_i,
  output logic             busy_o,
  output logic [NUM_W-1:0] num_o,
  output logic             commit_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W-1:0] num_q;
  logic             num_ok;

  assign num_ok = (num_i != 16'd0) && (num_i <= 16'(NUM_OBJ));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      num_q  <= '0;
    end else if (start_i && !busy_q && num_ok) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(XFER_CYC - 1);
      num_q  <= num_i[NUM_W-1:0];
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign commit_o = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;
  assign num_o    = num_q;

  // R4
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_q) |=> $stable(num_q));
  // R3
  bad_num_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && !num_ok) |=> !busy_q);
  // R2
  commit_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_q);
endmodule

// File: rtl/msg_obj_ram.sv
module msg_obj_ram
  import msg_if_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       cm_i,
  input  obj_t             if_i,
  output obj_t             cur_o
);
  obj_t             ent_a [NUM_OBJ];
  obj_t             nxt;
  logic [FLD_N-1:0] fsel;

  assign fsel  = field_sel(cm_i);
  assign cur_o = ent_a[idx_i];

  always_comb begin
    for (int f = 0; f < FLD_N; f++)
      nxt[f] = (cm_i[CM_DIR] && fsel[f]) ? if_i[f] : cur_o[f];
    if (cm_i[CM_DIR]) begin
      if (cm_i[CM_NDTR]) nxt[F_CTL][CT_TXRQ] = 1'b1;
    end else begin
      if (cm_i[CM_CLRIP]) nxt[F_CTL][CT_INTPND] = 1'b0;
      if (cm_i[CM_NDTR])  nxt[F_CTL][CT_NEWDAT] = 1'b0;
    end
  end

  for (genvar e = 0; e < NUM_OBJ; e++) begin : g_ent
    obj_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q <= '0;
      else if (commit_i && idx_i == IDX_W'(e))       ent_q <= nxt;
    end
    assign ent_a[e] = ent_q;
  end

  // R8
  clr_ip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !cm_i[CM_DIR] && cm_i[CM_CLRIP]) |=> !ent_a[$past(idx_i)][F_CTL][CT_INTPND]);
  // R9
  txrq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cm_i[CM_DIR] && cm_i[CM_NDTR]) |=> ent_a[$past(idx_i)][F_CTL][CT_TXRQ]);
  // R7
  keep_msk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cm_i[CM_DIR] && !cm_i[CM_MSK]) |=> ent_a[$past(idx_i)][F_MSK1] == $past(cur_o[F_MSK1]));
endmodule

// File: rtl/msg_if_xfer.sv
module msg_if_xfer
  import msg_if_pkg::*;
#(
  parameter int NUM_OBJ  = 32,
  parameter int XFER_CYC = 6,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NUM_W   = $clog2(NUM_OBJ + 1);
  localparam int IDX_W   = $clog2(NUM_OBJ);
  localparam int A_CREQ  = 0;
  localparam int A_CMASK = 1;
  localparam int A_FLD0  = 2;

  logic             busy, commit, wr_ok;
  logic [NUM_W-1:0] num;
  logic [7:0]       cm_q;
  obj_t             if_q, cur;
  logic [FLD_N-1:0] fsel;

  assign wr_ok = wr_i && !busy;
  assign fsel  = field_sel(cm_q);

  msg_xfer_seq #(.NUM_OBJ(NUM_OBJ), .XFER_CYC(XFER_CYC)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr_i && addr_i == ADDR_W'(A_CREQ)),
    .num_i    (wdata_i[15:0]),
    .busy_o   (busy),
    .num_o    (num),
    .commit_o (commit)
  );

  msg_obj_ram #(.NUM_OBJ(NUM_OBJ)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .idx_i    (IDX_W'(num - NUM_W'(1))),
    .cm_i     (cm_q),
    .if_i     (if_q),
    .cur_o    (cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cm_q <= '0;
    else if (wr_ok && addr_i == ADDR_W'(A_CMASK)) cm_q <= wdata_i[7:0];
  end

  // staging fields: loaded by a read transfer or by the CPU while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) if_q <= '0;
    else begin
      for (int f = 0; f < FLD_N; f++) begin
        if (commit && !cm_q[CM_DIR] && fsel[f])
          if_q[f] <= cur[f];
        else if (wr_ok && addr_i == ADDR_W'(A_FLD0 + f))
          if_q[f] <= wdata_i[15:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CREQ)) begin
      rdata_o[15]        = busy;
      rdata_o[NUM_W-1:0] = num;
    end else if (addr_i == ADDR_W'(A_CMASK)) begin
      rdata_o[7:0] = cm_q;
    end else begin
      for (int f = 0; f < FLD_N; f++)
        if (addr_i == ADDR_W'(A_FLD0 + f)) rdata_o[15:0] = if_q[f];
    end
  end

  // R4
  busy_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy && addr_i == ADDR_W'(A_CMASK)) |=> $stable(cm_q));
  // R7
  keep_if_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !cm_q[CM_DIR] && !cm_q[CM_ARB]) |=> $stable(if_q[F_ARB1]));
endmodule

// File: tb/msg_if_xfer_test.sv
`timescale 1ns/1ps
module msg_if_xfer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [15:0] m_ram [1:32][0:8];
  logic [15:0] m_if [0:8];
  logic [7:0]  m_cm;
  logic [5:0]  m_num;

  always #2.5 clk = ~clk;

  msg_if_xfer uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a == 1) m_cm = d[7:0];
    else if (a >= 2 && a <= 10) m_if[a-2] = d[15:0];
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = 4'(a);
    #1 chk(rdata, exp, tag);
  endtask

  function automatic bit grp(input logic [7:0] cm, input int f);
    if (f <= 1) return cm[6];
    if (f <= 3) return cm[5];
    if (f == 4) return cm[4];
    if (f <= 6) return cm[1];
    return cm[0];
  endfunction

  task automatic model_xfer(input int n);
    if (m_cm[7]) begin
      for (int f = 0; f < 9; f++) if (grp(m_cm, f)) m_ram[n][f] = m_if[f];
      if (m_cm[2]) m_ram[n][4][8] = 1'b1;
    end else begin
      for (int f = 0; f < 9; f++) if (grp(m_cm, f)) m_if[f] = m_ram[n][f];
      if (m_cm[3]) m_ram[n][4][13] = 1'b0;
      if (m_cm[2]) m_ram[n][4][15] = 1'b0;
    end
  endtask

  task automatic xfer(input int n, input logic [7:0] cm, input int poke, input string tag);
    wr_reg(1, {24'd0, cm});
    @(negedge clk);
    addr = 4'd0; wdata = 32'(n); wr = 1'b1;
    @(posedge clk);
    m_num = 6'(n);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      addr = 4'd0;
      if (poke != 0 && i == 2) begin wr = 1'b1; wdata = 32'(poke); end
      else wr = 1'b0;
      #1 chk(rdata, {16'd0, 1'b1, 9'd0, m_num}, {tag, " R2 busy window"});
    end
    @(negedge clk);
    wr = 1'b0;
    #1 chk(rdata, {16'd0, 1'b0, 9'd0, m_num}, {tag, " R2 busy end"});
    model_xfer(n);
  endtask

  task automatic bad_start(input logic [31:0] v, input string tag);
    @(negedge clk);
    addr = 4'd0; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    #1 chk(rdata, {16'd0, 1'b0, 9'd0, m_num}, {tag, " R3 no start"});
  endtask

  task automatic check_if(input string tag);
    rd_chk(1, {24'd0, m_cm}, {tag, " cmask"});
    for (int f = 0; f < 9; f++) rd_chk(2 + f, {16'd0, m_if[f]}, tag);
  endtask

  task automatic load_if(input logic [15:0] seed);
    for (int f = 0; f < 9; f++) wr_reg(2 + f, {16'hdead, 16'(seed * 16'h0101 + 16'(f) * 16'h1357)});
  endtask

  task automatic load_zero();
    for (int f = 0; f < 9; f++) wr_reg(2 + f, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int n = 1; n <= 32; n++) for (int f = 0; f < 9; f++) m_ram[n][f] = '0;
    for (int f = 0; f < 9; f++) m_if[f] = '0;
    m_cm = '0; m_num = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk(0, 32'd0, "R1 creq");
    check_if("R1 staging");
    rd_chk(11, 32'd0, "R10 unmapped");
    xfer(20, 8'h73, 0, "R1 ram");
    check_if("R1 object zero");

    // R10 register map readback, upper bits dropped
    load_if(16'h11);
    check_if("R10 map");

    // R5/R6 full write then full read, end objects
    xfer(5, 8'hF3, 0, "R5 w5");
    load_if(16'h22);
    xfer(32, 8'hF3, 0, "R5 w32");
    load_if(16'h33);
    xfer(1, 8'hF3, 0, "R5 w1");
    load_zero();
    xfer(5, 8'h73, 0, "R6 r5");
    check_if("R6 obj5");
    xfer(32, 8'h73, 0, "R6 r32");
    check_if("R6 obj32");
    xfer(1, 8'h73, 0, "R6 r1");
    check_if("R6 obj1");

    // R7 partial write: arbitration only, then data low half only
    load_if(16'h44);
    xfer(5, 8'hA0, 0, "R7 warb");
    load_if(16'h55);
    xfer(5, 8'h82, 0, "R7 wdlo");
    load_zero();
    xfer(5, 8'h73, 0, "R7 r5");
    check_if("R7 partial write");

    // R7 partial read: mask + data high only
    load_if(16'h66);
    xfer(32, 8'h41, 0, "R7 rpart");
    check_if("R7 partial read");

    // R8 clears on read
    wr_reg(6, 32'h0000_A005);
    xfer(7, 8'h90, 0, "R8 wctl");
    wr_reg(6, 32'd0);
    xfer(7, 8'h78, 0, "R8 clrip");
    check_if("R8 pre-clear copy");
    xfer(7, 8'h74, 0, "R8 clrnd");
    check_if("R8 after ip clear");
    xfer(7, 8'h70, 0, "R8 r7");
    check_if("R8 both cleared");

    // R9 transmit request set on write
    wr_reg(6, 32'h0000_0003);
    xfer(9, 8'h94, 0, "R9 wctl");
    xfer(10, 8'h84, 0, "R9 nosel");
    wr_reg(6, 32'd0);
    xfer(9, 8'h70, 0, "R9 r9");
    check_if("R9 obj9 ctl");
    xfer(10, 8'h70, 0, "R9 r10");
    check_if("R9 obj10 ctl");

    // R4 request poked during busy is dropped
    load_if(16'h77);
    xfer(3, 8'hF3, 4, "R4 poke");
    rd_chk(0, {16'd0, 1'b0, 9'd0, 6'd3}, "R4 num kept");
    load_zero();
    xfer(4, 8'h73, 0, "R4 r4");
    check_if("R4 obj4 untouched");
    xfer(3, 8'h73, 0, "R4 r3");
    check_if("R4 obj3 written");

    // R3 out-of-range numbers
    load_if(16'h88);
    bad_start(32'd0, "R3 zero");
    bad_start(32'd33, "R3 33");
    bad_start(32'd257, "R3 257");
    check_if("R3 staging unchanged");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule